// File: doc/BRIEF.md
# Clock Synthesizer Start-Up Supervisor

This block brings an on-chip frequency synthesizer out of power-up in a controlled way. It holds the synthesizer in reset for a fixed number of cycles and then releases it. After a settling window it looks at the lock indication. If the synthesizer has not locked by then, the block starts a fresh attempt with a new reset pulse. The rest of the chip is held in reset until lock has been confirmed and has then stayed present for a short release delay.

The supervisor runs only from a free-running reference clock that is independent of the synthesizer. Its timing therefore stays valid while the synthesizer output is unstable or stopped. The lock input is asynchronous and passes through a two-flop synchronizer. If lock is lost while the chip is running, the design reset is applied again and the attempt sequence restarts. A saturating counter records how many attempts have failed. A two-bit phase code reports whether the block is pulsing, waiting or running.

Pulse width, settling window and release delay are parameters counted in reference-clock cycles. The real values (on the order of microseconds for the pulse and hundreds of microseconds for the settling window) can be cut to a few cycles in simulation.

Top module: `clksyn_supervisor`

States and transitions:
- PULSE → SETTLE when the pulse timer expires.
- SETTLE → RELEASE when the window expires with synchronized lock high.
- SETTLE → PULSE (retry) when the window expires with lock low.
- RELEASE → RUN when the release timer expires with lock still high.
- RELEASE → PULSE and RUN → PULSE when synchronized lock goes low.

## Requirements
- R1: `syn_rst` is high for exactly PULSE_CYC consecutive clock cycles at the start of every attempt, including the first attempt after `rst_ext` is released.
- R2: Lock is judged once per attempt, at the clock edge SETTLE_CYC cycles after `syn_rst` falls. The value judged is `lock_raw` delayed by two synchronizer flops. A `lock_raw` rise driven up to SETTLE_CYC-3 cycles after the fall is accepted, and a rise one cycle later is not.
- R3: When lock is absent at the judging edge, `syn_rst` rises on that same edge and `retry_cnt` increases by one.
- R4: `core_rst` is high in every state except RUN, so it is never low while `syn_rst` is high. After a successful judgement it falls RELEASE_CYC cycles later, as long as lock stays high. With lock present from the pulse end, this is PULSE_CYC+SETTLE_CYC+RELEASE_CYC cycles after reset release.
- R5: If synchronized lock goes low during RELEASE or RUN, `core_rst` and `syn_rst` are high after the third clock edge following the `lock_raw` fall, a new attempt begins, and `retry_cnt` increases by one.
- R6: `retry_cnt` never decreases except on `rst_ext` and saturates at all ones.
- R7: `phase` is 2'b00 while pulsing, 2'b01 while settling or in the release delay, and 2'b10 while running. The value 2'b11 never appears.
- R8: `rst_ext` acts asynchronously. It forces `syn_rst`=1, `core_rst`=1, `phase`=2'b00 and `retry_cnt`=0 at once, and clears the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_free | input | 1 | Free-running reference clock, independent of the synthesizer |
| rst_ext | input | 1 | Asynchronous active-high reset |
| lock_raw | input | 1 | Asynchronous lock indication from the synthesizer |
| syn_rst | output | 1 | Reset to the synthesizer, active high |
| core_rst | output | 1 | Reset to the rest of the design, active high |
| phase | output | 2 | 00 pulsing, 01 waiting, 10 running |
| retry_cnt | output | RETRY_W | Saturating count of failed or lost attempts |

## Verification
Inputs are driven on the falling clock edge and outputs are read on the next falling edge, so every latency is counted in whole rising edges.

- A `lock_raw` change reaches the judging logic two edges later, so a drop shows up on `core_rst` at the third edge.
- Pulse length and the full release latency are measured as counts of falling edges from reset release and compared with PULSE_CYC and PULSE_CYC+SETTLE_CYC+RELEASE_CYC.
- The sample-window boundary is probed by raising lock at SETTLE_CYC-3 and at SETTLE_CYC-2 cycles after the pulse ends, then reading the outputs one cycle after the judging edge.
- Under random lock delays and hold times, a bench model advanced on each rising edge supplies the expected outputs for every falling-edge sample.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        S_PULSE   = 2'd0,
        S_SETTLE  = 2'd1,
        S_RELEASE = 2'd2,
        S_RUN     = 2'd3
    } supv_state_t;

    typedef enum logic [1:0] {
        PH_PULSE = 2'b00,
        PH_WAIT  = 2'b01,
        PH_RUN   = 2'b10
    } supv_phase_t;

endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic meta;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            meta   <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            meta   <= d_async;
            q_sync <= meta;
        end
    end
endmodule

// File: rtl/supv_timer.sv
module supv_timer #(
    parameter int TW        = 8,
    parameter int RESET_VAL = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            cnt <= TW'(RESET_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/supv_retry.sv
module supv_retry #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bump,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            count <= '0;
        else if (bump && (count != {W{1'b1}}))
            count <= count + W'(1);
    end
endmodule

// File: rtl/clksyn_supervisor.sv
module clksyn_supervisor
    import supv_pkg::*;
#(
    parameter int PULSE_CYC   = 500,
    parameter int SETTLE_CYC  = 10000,
    parameter int RELEASE_CYC = 16,
    parameter int RETRY_W     = 8
) (
    input  logic               clk_free,
    input  logic               rst_ext,
    input  logic               lock_raw,
    output logic               syn_rst,
    output logic               core_rst,
    output logic [1:0]         phase,
    output logic [RETRY_W-1:0] retry_cnt
);
    localparam int MAXC = (PULSE_CYC > SETTLE_CYC) ?
                          ((PULSE_CYC > RELEASE_CYC) ? PULSE_CYC : RELEASE_CYC) :
                          ((SETTLE_CYC > RELEASE_CYC) ? SETTLE_CYC : RELEASE_CYC);
    localparam int TW = $clog2(MAXC + 1);
    localparam logic [TW-1:0] LD_PULSE   = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] LD_SETTLE  = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] LD_RELEASE = TW'(RELEASE_CYC - 1);

    supv_state_t   state, state_nxt;
    logic          lock_s;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_done;
    logic          retry_bump;

    supv_sync2 u_sync (
        .clk     (clk_free),
        .rst     (rst_ext),
        .d_async (lock_raw),
        .q_sync  (lock_s)
    );

    supv_timer #(.TW(TW), .RESET_VAL(PULSE_CYC - 1)) u_timer (
        .clk      (clk_free),
        .rst      (rst_ext),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_done)
    );

    supv_retry #(.W(RETRY_W)) u_retry (
        .clk   (clk_free),
        .rst   (rst_ext),
        .bump  (retry_bump),
        .count (retry_cnt)
    );

    // state register
    always_ff @(posedge clk_free or posedge rst_ext) begin
        if (rst_ext)
            state <= S_PULSE;
        else
            state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt  = state;
        t_load     = 1'b0;
        t_val      = '0;
        retry_bump = 1'b0;
        unique case (state)
            S_PULSE: begin
                if (t_done) begin
                    state_nxt = S_SETTLE;
                    t_load    = 1'b1;
                    t_val     = LD_SETTLE;
                end
            end
            S_SETTLE: begin
                if (t_done) begin
                    if (lock_s) begin
                        state_nxt = S_RELEASE;
                        t_load    = 1'b1;
                        t_val     = LD_RELEASE;
                    end else begin
                        state_nxt  = S_PULSE;
                        t_load     = 1'b1;
                        t_val      = LD_PULSE;
                        retry_bump = 1'b1;
                    end
                end
            end
            S_RELEASE: begin
                if (!lock_s) begin
                    state_nxt  = S_PULSE;
                    t_load     = 1'b1;
                    t_val      = LD_PULSE;
                    retry_bump = 1'b1;
                end else if (t_done) begin
                    state_nxt = S_RUN;
                end
            end
            S_RUN: begin
                if (!lock_s) begin
                    state_nxt  = S_PULSE;
                    t_load     = 1'b1;
                    t_val      = LD_PULSE;
                    retry_bump = 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            S_PULSE: begin
                syn_rst  = 1'b1;
                core_rst = 1'b1;
                phase    = PH_PULSE;
            end
            S_SETTLE, S_RELEASE: begin
                syn_rst  = 1'b0;
                core_rst = 1'b1;
                phase    = PH_WAIT;
            end
            S_RUN: begin
                syn_rst  = 1'b0;
                core_rst = 1'b0;
                phase    = PH_RUN;
            end
        endcase
    end
endmodule

// File: rtl/supv_checker.sv
module supv_checker #(
    parameter int PULSE_CYC = 500,
    parameter int RETRY_W   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               lock_sync,
    input logic               syn_rst,
    input logic               core_rst,
    input logic [1:0]         phase,
    input logic [RETRY_W-1:0] retry_cnt
);
    localparam int HW = $clog2(PULSE_CYC + 2);
    localparam logic [RETRY_W-1:0] RMAX = {RETRY_W{1'b1}};

    logic [HW-1:0] hi_run;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            hi_run <= '0;
        else if (!syn_rst)
            hi_run <= '0;
        else if (hi_run != {HW{1'b1}})
            hi_run <= hi_run + HW'(1);
    end

    a_r1_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $fell(syn_rst) |-> (hi_run == HW'(PULSE_CYC)));

    a_r1_pulse_max: assert property (@(posedge clk) disable iff (rst)
        syn_rst |-> (hi_run < HW'(PULSE_CYC)));

    a_r3_retry_step: assert property (@(posedge clk) disable iff (rst)
        $rose(syn_rst) |-> ((retry_cnt == $past(retry_cnt) + RETRY_W'(1)) ||
                            (($past(retry_cnt) == RMAX) && (retry_cnt == RMAX))));

    a_r4_order: assert property (@(posedge clk) disable iff (rst)
        syn_rst |-> core_rst);

    a_r4_run_needs_lock: assert property (@(posedge clk) disable iff (rst)
        !core_rst |-> $past(lock_sync));

    a_r5_drop: assert property (@(posedge clk) disable iff (rst)
        (!core_rst && !lock_sync) |=> (core_rst && syn_rst));

    a_r6_retry_mono: assert property (@(posedge clk) disable iff (rst)
        retry_cnt >= $past(retry_cnt));

    a_r7_phase_legal: assert property (@(posedge clk) disable iff (rst)
        phase != 2'b11);

    a_r7_phase_run: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b10) == !core_rst);
endmodule

bind clksyn_supervisor supv_checker #(
    .PULSE_CYC (PULSE_CYC),
    .RETRY_W   (RETRY_W)
) u_supv_chk (
    .clk       (clk_free),
    .rst       (rst_ext),
    .lock_sync (lock_s),
    .syn_rst   (syn_rst),
    .core_rst  (core_rst),
    .phase     (phase),
    .retry_cnt (retry_cnt)
);

// File: tb/clksyn_supervisor_test.sv
`timescale 1ns/1ps
module clksyn_supervisor_test;
    localparam int P  = 4;
    localparam int S  = 20;
    localparam int R  = 3;
    localparam int W  = 4;

    logic clk = 1'b0;
    logic rst_ext = 1'b1;
    logic lock_raw = 1'b0;
    logic syn_rst, core_rst;
    logic [1:0] phase;
    logic [W-1:0] retry_cnt;

    int n_checks = 0;
    int n_err = 0;
    int mode = 2;          // 0 random lock, 1 never lock, 2 manual
    bit done = 1'b0;

    always #10 clk = ~clk;

    clksyn_supervisor #(.PULSE_CYC(P), .SETTLE_CYC(S), .RELEASE_CYC(R), .RETRY_W(W)) uut (
        .clk_free (clk),
        .rst_ext  (rst_ext),
        .lock_raw (lock_raw),
        .syn_rst  (syn_rst),
        .core_rst (core_rst),
        .phase    (phase),
        .retry_cnt(retry_cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // bench model of the required sequence, one step per rising edge
    int m_st, m_t, m_retry;
    logic m_s1, m_s2;

    function automatic int exp_syn(int st);   return (st == 0) ? 1 : 0; endfunction
    function automatic int exp_core(int st);  return (st == 3) ? 0 : 1; endfunction
    function automatic int exp_phase(int st); return (st == 0) ? 0 : ((st == 3) ? 2 : 1); endfunction
    function automatic int sat_inc(int v);    return (v == (1 << W) - 1) ? v : v + 1; endfunction

    always @(posedge clk or posedge rst_ext) begin
        if (rst_ext) begin
            m_st <= 0; m_t <= P - 1; m_retry <= 0; m_s1 <= 1'b0; m_s2 <= 1'b0;
        end else begin
            m_s1 <= lock_raw;
            m_s2 <= m_s1;
            case (m_st)
                0: if (m_t == 0) begin m_st <= 1; m_t <= S - 1; end else m_t <= m_t - 1;
                1: if (m_t == 0) begin
                       if (m_s2) begin m_st <= 2; m_t <= R - 1; end
                       else begin m_st <= 0; m_t <= P - 1; m_retry <= sat_inc(m_retry); end
                   end else m_t <= m_t - 1;
                2: if (!m_s2) begin m_st <= 0; m_t <= P - 1; m_retry <= sat_inc(m_retry); end
                   else if (m_t == 0) m_st <= 3;
                   else m_t <= m_t - 1;
                default: if (!m_s2) begin m_st <= 0; m_t <= P - 1; m_retry <= sat_inc(m_retry); end
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst_ext && !done) begin
            check("R1 syn_rst vs model",   int'(syn_rst),   exp_syn(m_st));
            check("R4 core_rst vs model",  int'(core_rst),  exp_core(m_st));
            check("R7 phase vs model",     int'(phase),     exp_phase(m_st));
            check("R6 retry_cnt vs model", int'(retry_cnt), m_retry);
        end
    end

    // lock source model: random delay after pulse end, random hold time
    initial begin
        int cnt, d, h;
        cnt = 0; d = 0; h = 0;
        forever begin
            @(negedge clk);
            if (mode == 1) begin
                lock_raw = 1'b0;
            end else if (mode == 0) begin
                if (syn_rst) begin
                    lock_raw = 1'b0;
                    cnt = 0;
                    d = $urandom_range(0, 2 * S);
                    h = $urandom_range(1, 80);
                end else begin
                    if (cnt == d) lock_raw = 1'b1;
                    if (cnt == d + h) lock_raw = 1'b0;
                    cnt++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int n, rc;
        void'($urandom(32'h1F2E3D4C));
        mode = 2;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 reset syn_rst", int'(syn_rst), 1);
        check("R8 reset core_rst", int'(core_rst), 1);
        check("R8 reset phase", int'(phase), 0);
        check("R8 reset retry", int'(retry_cnt), 0);

        // R1 pulse width and R4 release latency, lock raised at pulse end
        rst_ext = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (syn_rst);
        check("R1 pulse width", n, P);
        lock_raw = 1'b1;
        do begin @(negedge clk); n++; end while (core_rst);
        check("R4 release latency", n, P + S + R);
        check("R3 no retry on success", int'(retry_cnt), 0);

        // R5 lock drop while running
        repeat (5) @(negedge clk);
        lock_raw = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!core_rst && n < 10);
        check("R5 drop latency", n, 3);
        check("R5 new pulse on drop", int'(syn_rst), 1);
        check("R5 retry after drop", int'(retry_cnt), 1);

        // R2 late edge of acceptance window: accepted
        while (syn_rst) @(negedge clk);
        repeat (S - 3) @(negedge clk);
        lock_raw = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 lock at S-3 accepted phase", int'(phase), 1);
        check("R2 lock at S-3 accepted syn_rst", int'(syn_rst), 0);
        while (core_rst) @(negedge clk);
        lock_raw = 1'b0;
        while (!syn_rst) @(negedge clk);
        rc = int'(retry_cnt);

        // R2 one cycle later: rejected, R3 retry
        while (syn_rst) @(negedge clk);
        repeat (S - 2) @(negedge clk);
        lock_raw = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 lock at S-2 rejected", int'(syn_rst), 1);
        check("R3 retry increments", int'(retry_cnt), rc + 1);

        // random lock behaviour
        mode = 0;
        repeat (4000) @(negedge clk);

        // R6 saturation with no lock at all
        mode = 1;
        repeat (20 * (P + S + 1)) @(negedge clk);
        check("R6 retry saturates", int'(retry_cnt), (1 << W) - 1);
        check("R4 held without lock", int'(core_rst), 1);

        // R8 asynchronous reset between edges
        mode = 0;
        repeat (37) @(negedge clk);
        #2 rst_ext = 1'b1;
        #1;
        check("R8 async syn_rst", int'(syn_rst), 1);
        check("R8 async core_rst", int'(core_rst), 1);
        check("R8 async phase", int'(phase), 0);
        check("R8 async retry", int'(retry_cnt), 0);
        @(negedge clk);
        rst_ext = 1'b0;
        repeat (600) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule